// File: doc/BRIEF.md
# Per-Channel Fault Diagnostic Sequencer

This block drives one low-side gate output and sorts the digital comparator results taken from that channel's drain feedback into a 2-bit fault code. The gate goes high only when power is good, both enables are high, the channel is not shut down for a shorted load, and at least one of its two command sources (a parallel pin or a register bit) asks for it. Each change of the actual gate level starts a blanking interval. The interval is short after turn-on and long after turn-off. The drain is judged only when that interval ends. Once the channel has settled, a comparator change into a fault zone starts a short glitch filter, and the result is taken when the filter ends.

The first fault found is held in a latch until the host marks a valid serial frame with `frame_clr`. A shorted load always forces the gate low. In latch-off mode the gate stays low until the command is taken away and given again. In auto-retry mode the block sends a one-cycle request to a shared refresh timer and waits for that timer's completion pulse. It then drives the gate again, and the turn-on blanking that follows re-checks the channel. All intervals are counted in `tick` pulses, so the host clock can run at any rate.

Top module: `chan_fault_seq`

## Requirements
- R1: `gate` is a register that follows `por_ok & ena1 & ena2 & !shutdown & (par_in | gsel)` one clock later; while any enable is low, `gate` is 0 from the next clock on.
- R2: A change of `gate` starts a blanking interval of ON_TICKS (default 11) ticks after a rise or OFF_TICKS (default 60) ticks after a fall. The drain is judged only when the interval ends, so `fault_code` stays 00 during blanking.
- R3: With the gate off, the result is 10 (short to ground) when `cmp_gnd` is 1. It is 01 (open load) when `cmp_gnd` is 0 and `cmp_open` is 1. It is 00 (no fault) when both are 0.
- R4: With the gate on, `cmp_short`=1 gives result 11 (shorted load) and sets the shutdown, so `gate` goes to 0.
- R5: In the settled state, a comparator change into a fault zone starts a FLT_TICKS (default 6) tick filter. The fault is recorded only if it is still present when the filter ends, so a shorter glitch leaves `fault_code` at 00.
- R6: A change from a fault zone to the no-fault zone starts no filter and records nothing.
- R7: `fault_code` holds the first non-zero result. Later results are ignored until a one-cycle `frame_clr` pulse, which returns the code to 00 and re-arms the latch.
- R8: When `latch_mode`=1, a shorted load keeps `gate` at 0 until the command drops, either through `par_in`/`gsel` both going low or through `ena2` going low, and then returns.
- R9: When `latch_mode`=0, a shorted load gives exactly one `retry_req` pulse. `gate` stays 0 until a `retry_done` pulse arrives and then turns on again, followed by a turn-on blanking re-check.
- R10: `ena1` or `por_ok` low clears `fault_code` to 00 and clears the shutdown. Diagnostics are idle while any enable is low. A new blanking interval starts when all of them are high again.
- R11: The interval counters advance only on clocks with `tick`=1; with `tick` held low no result is ever taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| por_ok | input | 1 | Supply good (low acts as power-on reset) |
| ena1 | input | 1 | Master enable; low also clears fault state |
| ena2 | input | 1 | Output enable |
| par_in | input | 1 | Parallel gate command |
| gsel | input | 1 | Register gate command bit |
| latch_mode | input | 1 | 1 = latch-off, 0 = auto-retry on shorted load |
| tick | input | 1 | Interval time base pulse |
| cmp_short | input | 1 | Drain above shorted-load threshold |
| cmp_open | input | 1 | Drain below open-load reference |
| cmp_gnd | input | 1 | Drain below short-to-ground reference |
| frame_clr | input | 1 | Valid frame pulse: clear and re-arm fault latch |
| retry_done | input | 1 | Refresh period over pulse from shared timer |
| gate | output | 1 | Gate drive |
| retry_req | output | 1 | One-cycle request to start the refresh timer |
| fault_code | output | 2 | Latched fault code |

## Verification
The hardest case to reach is a comparator change that occurs only after the channel has settled. That event must be brief enough for the filter to reject it, or long enough for the filter to accept it, and it must arrive after blanking has ended and the latch has been re-armed. The stimulus reaches that case in three steps. It latches an off-state fault through the long blanking interval. It then clears the latch with a frame pulse and moves the drain to the no-fault zone. Last, it applies a three-cycle open-load glitch and then a held open-load level. The shorted-load recovery paths are reached by holding `cmp_short` high through turn-on and then withdrawing the command through each source in turn, or by supplying the refresh completion pulse.

// File: rtl/fdiag_pkg.sv
package fdiag_pkg;
  typedef enum logic [1:0] {
    FC_NONE  = 2'b00,
    FC_OPEN  = 2'b01,
    FC_GND   = 2'b10,
    FC_SHORT = 2'b11
  } fcode_t;

  typedef enum logic [1:0] {
    DS_OFF,
    DS_BLANK,
    DS_STABLE,
    DS_FILTER
  } dstate_t;
endpackage

// File: rtl/fdiag_sync.sv
module fdiag_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/fdiag_timer.sv
module fdiag_timer #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          abort,
  input  logic [CW-1:0] lim,
  input  logic          tick,
  output logic          expire
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim_q;
  logic          running;

  assign expire = running && tick && !start && !abort && (cnt == lim_q - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      lim_q   <= CW'(1);
      running <= 1'b0;
    end else if (abort) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (start) begin
      cnt     <= '0;
      lim_q   <= lim;
      running <= 1'b1;
    end else if (running && tick) begin
      if (cnt == lim_q - CW'(1)) begin
        cnt     <= '0;
        running <= 1'b0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  // R2
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt < lim_q));
endmodule

// File: rtl/fdiag_latch.sv
module fdiag_latch
  import fdiag_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wipe,
  input  logic   clr,
  input  logic   cap,
  input  fcode_t cap_code,
  output fcode_t code
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code  <= FC_NONE;
      armed <= 1'b1;
    end else if (wipe) begin
      code  <= FC_NONE;
      armed <= 1'b1;
    end else if (clr) begin
      code  <= cap ? cap_code : FC_NONE;
      armed <= !cap;
    end else if (cap && armed) begin
      code  <= cap_code;
      armed <= 1'b0;
    end
  end

  // R7
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code != FC_NONE && !wipe && !clr) |=> (code == $past(code)));
endmodule

// File: rtl/chan_fault_seq.sv
module chan_fault_seq
  import fdiag_pkg::*;
#(
  parameter int ON_TICKS  = 11,
  parameter int OFF_TICKS = 60,
  parameter int FLT_TICKS = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_ok,
  input  logic       ena1,
  input  logic       ena2,
  input  logic       par_in,
  input  logic       gsel,
  input  logic       latch_mode,
  input  logic       tick,
  input  logic       cmp_short,
  input  logic       cmp_open,
  input  logic       cmp_gnd,
  input  logic       frame_clr,
  input  logic       retry_done,
  output logic       gate,
  output logic       retry_req,
  output logic [1:0] fault_code
);
  localparam int MAXT = (OFF_TICKS > ON_TICKS) ?
                        ((OFF_TICKS > FLT_TICKS) ? OFF_TICKS : FLT_TICKS) :
                        ((ON_TICKS > FLT_TICKS) ? ON_TICKS : FLT_TICKS);
  localparam int CW = $clog2(MAXT + 1);
  localparam logic [CW-1:0] ON_L  = CW'(ON_TICKS);
  localparam logic [CW-1:0] OFF_L = CW'(OFF_TICKS);
  localparam logic [CW-1:0] FLT_L = CW'(FLT_TICKS);

  logic [2:0] cmp_s;
  logic       s_short, s_open, s_gnd;
  logic       diag_en, cmd;
  logic       gate_q, on_prev, en_prev, shut_q;
  dstate_t    st;
  fcode_t     cls, cls_q, latched;
  logic       blank_start, flt_start, tmr_start, expire, res_valid, shorted;
  logic [CW-1:0] lim;

  fdiag_sync #(.W(3)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({cmp_short, cmp_open, cmp_gnd}),
    .q(cmp_s)
  );
  assign {s_short, s_open, s_gnd} = cmp_s;

  assign diag_en = por_ok && ena1 && ena2;
  assign cmd     = par_in || gsel;

  always_comb begin
    if (gate_q)      cls = s_short ? FC_SHORT : FC_NONE;
    else if (s_gnd)  cls = FC_GND;
    else if (s_open) cls = FC_OPEN;
    else             cls = FC_NONE;
  end

  assign blank_start = diag_en && (!en_prev || (gate_q != on_prev));
  assign flt_start   = diag_en && !blank_start && (st == DS_STABLE) &&
                       (cls != cls_q) && (cls != FC_NONE);
  assign tmr_start   = blank_start || flt_start;
  assign lim         = blank_start ? (gate_q ? ON_L : OFF_L) : FLT_L;

  fdiag_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .start(tmr_start), .abort(!diag_en),
    .lim(lim), .tick(tick), .expire(expire)
  );

  assign res_valid = expire && diag_en && !blank_start &&
                     ((st == DS_BLANK) || (st == DS_FILTER));
  assign shorted   = res_valid && (cls == FC_SHORT);
  assign retry_req = shorted && !latch_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q  <= 1'b0;
      on_prev <= 1'b0;
      en_prev <= 1'b0;
      shut_q  <= 1'b0;
      st      <= DS_OFF;
      cls_q   <= FC_NONE;
    end else begin
      gate_q  <= diag_en && cmd && !shut_q;
      on_prev <= gate_q;
      en_prev <= diag_en;
      cls_q   <= cls;
      if (!por_ok || !ena1)                shut_q <= 1'b0;
      else if (shorted)                    shut_q <= 1'b1;
      else if (!(cmd && ena2))             shut_q <= 1'b0;
      else if (!latch_mode && retry_done)  shut_q <= 1'b0;
      if (!diag_en)         st <= DS_OFF;
      else if (blank_start) st <= DS_BLANK;
      else if (flt_start)   st <= DS_FILTER;
      else if (res_valid)   st <= DS_STABLE;
    end
  end

  fdiag_latch u_latch (
    .clk(clk), .rst_n(rst_n),
    .wipe(!por_ok || !ena1),
    .clr(frame_clr),
    .cap(res_valid && (cls != FC_NONE)),
    .cap_code(cls),
    .code(latched)
  );

  assign gate       = gate_q;
  assign fault_code = latched;

  // R1
  gate_off_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !diag_en |=> !gate_q);
  // R4
  short_sets_shutdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shorted |=> shut_q);
  // R8
  latchoff_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shut_q && latch_mode && cmd && ena2 && ena1 && por_ok) |=> shut_q);
  // R10
  idle_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !diag_en |=> (st == DS_OFF));
endmodule

// File: tb/chan_fault_seq_bench.sv
module chan_fault_seq_bench;
  localparam int CLK_NS = 10;

  logic clk = 1'b0;
  logic rst_n, por_ok, ena1, ena2, par_in, gsel, latch_mode, tick;
  logic cmp_short, cmp_open, cmp_gnd, frame_clr, retry_done;
  logic gate, retry_req;
  logic [1:0] fault_code;

  int n_chk = 0;
  int n_bad = 0;
  int rcnt  = 0;
  int r0;
  bit finished = 0;

  always #(CLK_NS/2) clk = ~clk;

  chan_fault_seq u_chan_fault_seq (
    .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .ena1(ena1), .ena2(ena2),
    .par_in(par_in), .gsel(gsel), .latch_mode(latch_mode), .tick(tick),
    .cmp_short(cmp_short), .cmp_open(cmp_open), .cmp_gnd(cmp_gnd),
    .frame_clr(frame_clr), .retry_done(retry_done),
    .gate(gate), .retry_req(retry_req), .fault_code(fault_code)
  );

  always @(posedge clk) if (retry_req) rcnt <= rcnt + 1;

  // {cmd, mode, gnd, open, short, code[1:0], gate}
  localparam logic [7:0] VEC [6] = '{
    8'b0000_0000,  // R3 off, no fault
    8'b0001_0010,  // R3 off, open load
    8'b0011_0100,  // R3 off, short to ground
    8'b1000_0001,  // R2 on, healthy
    8'b1000_1110,  // R4 on, shorted, auto-retry
    8'b1100_1110   // R4 on, shorted, latch-off
  };

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic restart_diag;
    ena1 = 1'b0; ena2 = 1'b0;
    cyc(2);
  endtask

  task automatic enable_all;
    ena1 = 1'b1; ena2 = 1'b1;
  endtask

  task automatic pulse_clr;
    frame_clr = 1'b1; cyc(1); frame_clr = 1'b0;
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    summary();
  end

  initial begin
    rst_n = 0; por_ok = 0; ena1 = 0; ena2 = 0; par_in = 0; gsel = 0;
    latch_mode = 0; tick = 1; cmp_short = 0; cmp_open = 0; cmp_gnd = 0;
    frame_clr = 0; retry_done = 0;
    cyc(3);
    chk("R1 reset gate", {1'b0, gate}, 2'd0);
    chk("R10 reset code", fault_code, 2'd0);
    rst_n = 1; por_ok = 1;
    cyc(2);

    for (int i = 0; i < 6; i++) begin
      restart_diag();
      gsel = VEC[i][7]; latch_mode = VEC[i][6]; cmp_gnd = VEC[i][5];
      cmp_open = VEC[i][4]; cmp_short = VEC[i][3];
      cyc(3);
      enable_all();
      cyc(100);
      chk($sformatf("R3 R4 vector %0d code", i), fault_code, VEC[i][2:1]);
      chk($sformatf("R1 vector %0d gate", i), {1'b0, gate}, {1'b0, VEC[i][0]});
    end
    gsel = 0; cmp_short = 0; cmp_open = 0; cmp_gnd = 0; latch_mode = 0;

    // R2 off blanking window
    restart_diag();
    cmp_open = 1; cyc(3);
    enable_all();
    cyc(40);
    chk("R2 no result inside blanking", fault_code, 2'd0);
    cyc(30);
    chk("R2 result after blanking", fault_code, 2'd1);

    // R7 later fault ignored, then clear
    cmp_gnd = 1; cyc(20);
    chk("R7 first fault held", fault_code, 2'd1);
    pulse_clr(); cyc(2);
    chk("R7 frame clears code", fault_code, 2'd0);

    // R6 fault to good zone
    cmp_gnd = 0; cmp_open = 0; cyc(20);
    chk("R6 good zone records nothing", fault_code, 2'd0);

    // R5 glitch rejected, held fault accepted
    cmp_open = 1; cyc(3); cmp_open = 0; cyc(20);
    chk("R5 glitch rejected", fault_code, 2'd0);
    cmp_open = 1; cyc(20);
    chk("R5 held fault captured", fault_code, 2'd1);
    cmp_open = 0;

    // R8 latch-off recovery through command and through ena2
    restart_diag();
    latch_mode = 1; par_in = 1; cmp_short = 1; cyc(3);
    enable_all();
    cyc(100);
    chk("R8 latched off", {1'b0, gate}, 2'd0);
    par_in = 0; cyc(3); cmp_short = 0; par_in = 1; cyc(30);
    chk("R8 command toggle recovers", {1'b0, gate}, 2'd1);
    cmp_short = 1; cyc(30);
    chk("R8 filtered short latches off", {1'b0, gate}, 2'd0);
    ena2 = 0; cyc(3); cmp_short = 0; ena2 = 1; cyc(30);
    chk("R8 ena2 toggle recovers", {1'b0, gate}, 2'd1);

    // R9 auto-retry handshake
    restart_diag();
    latch_mode = 0; par_in = 1; cmp_short = 1; cyc(3);
    r0 = rcnt;
    enable_all();
    cyc(40);
    chk("R9 gate low awaiting refresh", {1'b0, gate}, 2'd0);
    chk("R9 one retry request", (rcnt - r0 == 1) ? 2'd1 : 2'd0, 2'd1);
    cmp_short = 0; retry_done = 1; cyc(1); retry_done = 0;
    cyc(5);
    chk("R9 gate back after refresh", {1'b0, gate}, 2'd1);
    cyc(30);
    chk("R9 recheck keeps gate on", {1'b0, gate}, 2'd1);
    chk("R9 still one request", (rcnt - r0 == 1) ? 2'd1 : 2'd0, 2'd1);

    // R10 ena1 wipe
    chk("R10 code before wipe", fault_code, 2'd3);
    ena1 = 0; cyc(2);
    chk("R10 ena1 low clears code", fault_code, 2'd0);
    chk("R1 ena1 low gate off", {1'b0, gate}, 2'd0);
    ena1 = 1; cyc(3);
    chk("R10 gate after re-enable", {1'b0, gate}, 2'd1);
    por_ok = 0; cyc(2);
    chk("R1 por low gate off", {1'b0, gate}, 2'd0);
    por_ok = 1; par_in = 0;

    // R11 tick gating
    restart_diag();
    cmp_open = 1; tick = 0; cyc(3);
    enable_all();
    cyc(200);
    chk("R11 no tick no result", fault_code, 2'd0);
    tick = 1; cyc(70);
    chk("R11 ticks resume result", fault_code, 2'd1);

    summary();
  end
endmodule